// File: doc/BRIEF.md
# SDRAM Command Spacing Monitor

This block watches the command stream a memory controller sends to an SDRAM device and reports every command that arrives too soon after an earlier one. It does not drive the memory. It only observes the stream and flags problems, so it can sit beside a scheduler in a simulation or stay in silicon as a run-time guard. Each cycle it receives a valid flag, a command kind, a target bank and the bank group of that bank. Two kinds of rule are checked in parallel. Bank-local rules keep one tracker per bank. Device-wide rules keep one tracker shared by all banks.

The device-wide rules use a long minimum when the new command goes to the same bank group as the previous command of its kind, and a short minimum otherwise. A rolling window also limits how many activates may start within a set time. Every rule that a command breaks sets its own bit in a violation code. The result is registered and appears one cycle after the command. All state follows what the device actually received, so a command that breaks a rule still updates the history.

Top module: `sdram_spacing_monitor`

## Requirements
- R1: During reset and in the first cycle after it, `viol_o` and `viol_code_o` are zero. All rules start out satisfied, so the first command of each kind raises no flag.
- R2: A command counts only when `cmd_valid_i` is 1. The command encoding is 00 idle, 01 activate, 10 read, 11 write. Idle cycles and cycles with `cmd_valid_i` at 0 never raise a flag and change no state. They only let time pass.
- R3: The result for a command appears in the cycle after it. `viol_code_o` bit 0 is row cycle, bit 1 is activate-to-access, bit 2 is activate-to-activate, bit 3 is the four-activate window, bit 4 is access-to-access, and bit 5 is access to a closed row. Several bits may be set together. `viol_o` is 1 exactly when any bit is set.
- R4: An activate to a bank less than `T_RC` cycles after the previous activate to the same bank sets bit 0.
- R5: A read or write to a bank less than `T_RCD` cycles after the last activate to that bank sets bit 1.
- R6: An activate less than `T_RRD_L` cycles after the previous activate sets bit 2 when both target the same bank group. When the groups differ, the limit is `T_RRD_S` cycles.
- R7: An activate that comes fewer than `T_FAW` cycles after the fourth-most-recent activate sets bit 3. At exactly `T_FAW` cycles it is allowed.
- R8: A read or write less than `T_CCD_L` cycles after the previous read or write sets bit 4 when both target the same bank group. When the groups differ, the limit is `T_CCD_S` cycles.
- R9: A read or write to a bank whose row is closed sets bit 5. An activate opens the row. A read or write with `cmd_ap_i` at 1 closes it. A read or write with `cmd_ap_i` at 0 leaves it open.
- R10: A command that breaks a rule still counts as issued. It restarts every spacing measurement it belongs to.

Elapsed cycles are the difference between the cycle numbers of the two commands. A rule is broken when that difference is below the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_type_i | input | 2 | Command kind: 00 idle, 01 activate, 10 read, 11 write |
| cmd_bank_i | input | BANK_W | Target bank |
| cmd_group_i | input | GRP_W | Bank group of the target bank |
| cmd_ap_i | input | 1 | The read or write closes the row when it completes |
| viol_o | output | 1 | One-cycle pulse: the previous command broke at least one rule |
| viol_code_o | output | 6 | One bit per broken rule (see R3) |

## Verification
The bench places commands at exactly the limit and one cycle short of it, for both the row-cycle and the access-to-access rules. A monitor that compared with `<=` in place of `<` would flag the commands at the limit, and one that was off by a cycle would miss the short ones. Same-group and different-group pairs are sent back to back. A design that used only one of the two limits fails one pair or the other. The four-activate window is tested with a fifth activate that arrives one cycle early and with another at exactly the window. Because a flagged read restarts the access spacing, a later read is then measured from it, which catches a design that updates state only on clean commands. Further checks combine several broken rules in one command, and confirm that an activate sent with the valid flag low does not open a row.

// File: rtl/sdram_mon_pkg.sv
// Package: command encodings, violation bit positions and helpers
// shared by the spacing monitor and its sub-blocks.
package sdram_mon_pkg;

    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_ACT  = 2'd1;
    localparam logic [1:0] OP_RD   = 2'd2;
    localparam logic [1:0] OP_WR   = 2'd3;

    localparam int VB_RC     = 0;
    localparam int VB_RCD    = 1;
    localparam int VB_RRD    = 2;
    localparam int VB_FAW    = 3;
    localparam int VB_CCD    = 4;
    localparam int VB_CLOSED = 5;
    localparam int NUM_RULES = 6;

    // Number of activates held by the rolling activate window.
    localparam int WINDOW_ACTS = 4;

    // Larger of two integers (used to size elapsed-cycle counters).
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_bank_tracker.sv
// Tracks one bank: cycles since its last activate and whether its row
// is open. Flags row-cycle, activate-to-access and closed-row breaks.
// Assumes the elapsed counter saturates at a value >= every limit.
module sdram_bank_tracker #(
    parameter int CNT_W = 5,
    parameter int T_RC  = 10,
    parameter int T_RCD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic cas_i,
    input  logic ap_i,
    output logic rc_viol_o,
    output logic rcd_viol_o,
    output logic closed_viol_o
);
    localparam logic [CNT_W-1:0] RC_LIM  = CNT_W'(T_RC);
    localparam logic [CNT_W-1:0] RCD_LIM = CNT_W'(T_RCD);
    localparam logic [CNT_W-1:0] SAT     = '1;

    logic [CNT_W-1:0] since_act;
    logic             row_open;

    // Elapsed cycles since the last activate to this bank, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_act <= SAT;
        else if (act_i)            since_act <= CNT_W'(1);
        else if (since_act != SAT) since_act <= since_act + CNT_W'(1);
    end

    // Row state: an activate opens it, an access with auto-close shuts it.
    always_ff @(posedge clk) begin
        if (!rst_n)             row_open <= 1'b0;
        else if (act_i)         row_open <= 1'b1;
        else if (cas_i && ap_i) row_open <= 1'b0;
    end

    // Rule evaluation for the command seen this cycle.
    always_comb begin
        rc_viol_o     = act_i && (since_act < RC_LIM);
        rcd_viol_o    = cas_i && (since_act < RCD_LIM);
        closed_viol_o = cas_i && !row_open;
    end

    // R9
    act_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> row_open);
    // R9
    ap_closes_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_i && ap_i && !act_i) |=> !row_open);
    // R10
    act_restarts_rc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> (since_act == CNT_W'(1)));
endmodule

// File: rtl/sdram_act_window.sv
// Device-wide activate rules: activate-to-activate spacing (long limit
// inside one bank group, short limit across groups) and the rolling
// window over the last WINDOW_ACTS activates.
module sdram_act_window
    import sdram_mon_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int GRP_W   = 1,
    parameter int T_RRD_S = 2,
    parameter int T_RRD_L = 3,
    parameter int T_FAW   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [GRP_W-1:0] grp_i,
    output logic             rrd_viol_o,
    output logic             faw_viol_o
);
    localparam logic [CNT_W-1:0] RRD_S_LIM = CNT_W'(T_RRD_S);
    localparam logic [CNT_W-1:0] RRD_L_LIM = CNT_W'(T_RRD_L);
    localparam logic [CNT_W-1:0] FAW_LIM   = CNT_W'(T_FAW);
    localparam logic [CNT_W-1:0] SAT       = '1;

    logic [CNT_W-1:0] since_last;
    logic [GRP_W-1:0] last_grp;
    logic [CNT_W-1:0] age [WINDOW_ACTS];

    function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
        return (v == SAT) ? v : v + CNT_W'(1);
    endfunction

    // Elapsed cycles and group of the most recent activate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_last <= SAT;
            last_grp   <= '0;
        end else if (act_i) begin
            since_last <= CNT_W'(1);
            last_grp   <= grp_i;
        end else begin
            since_last <= bump(since_last);
        end
    end

    // Ages of the last activates; index WINDOW_ACTS-1 is the oldest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WINDOW_ACTS; k++) age[k] <= SAT;
        end else begin
            age[0] <= act_i ? CNT_W'(1) : bump(age[0]);
            for (int k = 1; k < WINDOW_ACTS; k++)
                age[k] <= act_i ? bump(age[k-1]) : bump(age[k]);
        end
    end

    // Rule evaluation for an activate seen this cycle.
    always_comb begin
        rrd_viol_o = act_i &&
            (since_last < ((grp_i == last_grp) ? RRD_L_LIM : RRD_S_LIM));
        faw_viol_o = act_i && (age[WINDOW_ACTS-1] < FAW_LIM);
    end

    // R7
    faw_age_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_i |=> (age[WINDOW_ACTS-1] >= $past(age[WINDOW_ACTS-1])));
    // R10
    rrd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> (since_last == CNT_W'(1) && last_grp == $past(grp_i)));
endmodule

// File: rtl/sdram_cas_spacing.sv
// Device-wide access spacing: a read or write must trail the previous
// read or write by the long limit inside one bank group, by the short
// limit across groups.
module sdram_cas_spacing #(
    parameter int CNT_W   = 5,
    parameter int GRP_W   = 1,
    parameter int T_CCD_S = 2,
    parameter int T_CCD_L = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cas_i,
    input  logic [GRP_W-1:0] grp_i,
    output logic             ccd_viol_o
);
    localparam logic [CNT_W-1:0] CCD_S_LIM = CNT_W'(T_CCD_S);
    localparam logic [CNT_W-1:0] CCD_L_LIM = CNT_W'(T_CCD_L);
    localparam logic [CNT_W-1:0] SAT       = '1;

    logic [CNT_W-1:0] since_cas;
    logic [GRP_W-1:0] cas_grp;

    // Elapsed cycles and group of the most recent read or write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cas <= SAT;
            cas_grp   <= '0;
        end else if (cas_i) begin
            since_cas <= CNT_W'(1);
            cas_grp   <= grp_i;
        end else if (since_cas != SAT) begin
            since_cas <= since_cas + CNT_W'(1);
        end
    end

    // Rule evaluation for an access seen this cycle.
    always_comb begin
        ccd_viol_o = cas_i &&
            (since_cas < ((grp_i == cas_grp) ? CCD_L_LIM : CCD_S_LIM));
    end

    // R8
    ccd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_i |=> (since_cas >= $past(since_cas)));
endmodule

// File: rtl/sdram_spacing_monitor.sv
// Top: decodes the observed command, fans it out to one tracker per bank
// and to the device-wide activate and access checkers, then registers the
// combined violation code. Assumes cmd_group_i is consistent per bank.
module sdram_spacing_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS  = 8,
    parameter int NUM_GROUPS = 2,
    parameter int T_RC       = 10,
    parameter int T_RCD      = 3,
    parameter int T_RRD_S    = 2,
    parameter int T_RRD_L    = 3,
    parameter int T_FAW      = 12,
    parameter int T_CCD_S    = 2,
    parameter int T_CCD_L    = 4,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid_i,
    input  logic [1:0]           cmd_type_i,
    input  logic [BANK_W-1:0]    cmd_bank_i,
    input  logic [GRP_W-1:0]     cmd_group_i,
    input  logic                 cmd_ap_i,
    output logic                 viol_o,
    output logic [NUM_RULES-1:0] viol_code_o
);
    localparam int T_MAX = imax(imax(imax(T_RC, T_RCD), imax(T_RRD_S, T_RRD_L)),
                                imax(T_FAW, imax(T_CCD_S, T_CCD_L)));
    localparam int CNT_W = $clog2(T_MAX + 1);

    logic                 is_act, is_cas;
    logic [NUM_BANKS-1:0] rc_b, rcd_b, closed_b;
    logic                 rrd_v, faw_v, ccd_v;
    logic [NUM_RULES-1:0] code_n;

    // Command decode, qualified by the valid flag.
    always_comb begin
        is_act = cmd_valid_i && (cmd_type_i == OP_ACT);
        is_cas = cmd_valid_i && (cmd_type_i == OP_RD || cmd_type_i == OP_WR);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (cmd_bank_i == BANK_W'(b));
        sdram_bank_tracker #(
            .CNT_W (CNT_W),
            .T_RC  (T_RC),
            .T_RCD (T_RCD)
        ) u_trk (
            .clk           (clk),
            .rst_n         (rst_n),
            .act_i         (is_act && hit),
            .cas_i         (is_cas && hit),
            .ap_i          (cmd_ap_i),
            .rc_viol_o     (rc_b[b]),
            .rcd_viol_o    (rcd_b[b]),
            .closed_viol_o (closed_b[b])
        );
    end

    sdram_act_window #(
        .CNT_W   (CNT_W),
        .GRP_W   (GRP_W),
        .T_RRD_S (T_RRD_S),
        .T_RRD_L (T_RRD_L),
        .T_FAW   (T_FAW)
    ) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (is_act),
        .grp_i      (cmd_group_i),
        .rrd_viol_o (rrd_v),
        .faw_viol_o (faw_v)
    );

    sdram_cas_spacing #(
        .CNT_W   (CNT_W),
        .GRP_W   (GRP_W),
        .T_CCD_S (T_CCD_S),
        .T_CCD_L (T_CCD_L)
    ) u_cas (
        .clk        (clk),
        .rst_n      (rst_n),
        .cas_i      (is_cas),
        .grp_i      (cmd_group_i),
        .ccd_viol_o (ccd_v)
    );

    // Gather every rule result into the code vector.
    always_comb begin
        code_n            = '0;
        code_n[VB_RC]     = |rc_b;
        code_n[VB_RCD]    = |rcd_b;
        code_n[VB_RRD]    = rrd_v;
        code_n[VB_FAW]    = faw_v;
        code_n[VB_CCD]    = ccd_v;
        code_n[VB_CLOSED] = |closed_b;
    end

    // Register the report one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_o      <= 1'b0;
            viol_code_o <= '0;
        end else begin
            viol_o      <= |code_n;
            viol_code_o <= code_n;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!viol_o && viol_code_o == '0));
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> ($past(cmd_valid_i) && $past(cmd_type_i) != OP_IDLE));
    // R3
    flag_code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (viol_code_o != '0));
endmodule

// File: tb/sdram_spacing_monitor_tb.sv
// Scoreboard bench: the driver task issues one command per cycle and
// queues the expected code; the monitor pops it after the result edge.
module sdram_spacing_monitor_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid_i = 1'b0;
    logic [1:0] cmd_type_i = 2'd0;
    logic [2:0] cmd_bank_i = 3'd0;
    logic [0:0] cmd_group_i = 1'b0;
    logic       cmd_ap_i = 1'b0;
    logic       viol_o;
    logic [5:0] viol_code_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    typedef struct {
        logic [5:0] code;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    localparam logic [1:0] I = 2'd0, A = 2'd1, RD = 2'd2, WR = 2'd3;
    localparam logic [5:0] C_RC = 6'b000001, C_RCD = 6'b000010, C_RRD = 6'b000100,
                           C_FAW = 6'b001000, C_CCD = 6'b010000, C_CL = 6'b100000;

    always #5 clk = ~clk;

    sdram_spacing_monitor u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid_i),
        .cmd_type_i  (cmd_type_i),
        .cmd_bank_i  (cmd_bank_i),
        .cmd_group_i (cmd_group_i),
        .cmd_ap_i    (cmd_ap_i),
        .viol_o      (viol_o),
        .viol_code_o (viol_code_o)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input int b, input int g,
                         input logic ap, input logic [5:0] exp, input string tag);
        exp_t it;
        @(negedge clk);
        cmd_valid_i = v;
        cmd_type_i  = op;
        cmd_bank_i  = 3'(b);
        cmd_group_i = 1'(g);
        cmd_ap_i    = ap;
        it.code = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(1'b1, I, 0, 0, 1'b0, 6'd0, "R2");
    endtask

    // Monitor: compare the registered result one cycle after each command.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            checks++;
            if (viol_code_o !== it.code || viol_o !== (|it.code)) begin
                fails++;
                $display("FAIL %s: code=%b flag=%b expected code=%b flag=%b",
                         it.tag, viol_code_o, viol_o, it.code, |it.code);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (viol_o !== 1'b0 || viol_code_o !== 6'd0) begin
            fails++;
            $display("FAIL R1: reset code=%b flag=%b expected code=000000 flag=0",
                     viol_code_o, viol_o);
        end
        rst_n = 1'b1;

        // Part A: access rules and row state (cycle numbers from 0)
        drive(1, A,  0, 0, 0, 6'd0,  "R1 first activate clean");
        drive(1, RD, 0, 0, 0, C_RCD, "R5 read 1 cycle after activate");
        idle(1);
        drive(1, RD, 0, 0, 0, C_CCD, "R10 R8 flagged read restarts access spacing");
        idle(3);
        drive(1, WR, 4, 1, 0, C_CL,  "R9 write to never-opened bank");
        drive(1, RD, 0, 0, 1, C_CCD, "R8 short limit across groups, R9 row kept open");
        idle(4);
        drive(1, RD, 0, 0, 0, C_CL,  "R9 auto-close shut the row");
        idle(14);

        // Part B: activate rules
        drive(1, A, 1, 0, 0, 6'd0,          "R6 clean activate");
        idle(1);
        drive(1, A, 2, 0, 0, C_RRD,         "R6 same group below long limit");
        idle(1);
        drive(1, A, 5, 1, 0, 6'd0,          "R6 other group at short limit");
        drive(1, A, 1, 0, 0, C_RC | C_RRD,  "R3 R4 two rules at once");
        idle(2);
        drive(1, A, 6, 1, 0, C_FAW,         "R7 fifth activate inside window");
        idle(5);
        drive(1, A, 7, 0, 0, 6'd0,          "R7 activate at window boundary");
        drive(1, A, 3, 1, 0, C_RRD | C_FAW, "R7 R6 window and spacing");
        idle(14);

        // Part C: boundaries and ignored commands
        drive(1, A, 0, 0, 0, 6'd0,   "R4 reopen bank 0");
        idle(8);
        drive(1, A, 0, 0, 0, C_RC,   "R4 one cycle short of row cycle");
        idle(9);
        drive(1, A, 0, 0, 0, 6'd0,   "R4 R10 row cycle measured from flagged activate");
        idle(2);
        drive(1, RD, 0, 0, 0, 6'd0,  "R5 read exactly at limit");
        idle(1);
        drive(1, WR, 0, 0, 0, C_CCD, "R8 same group below long limit");
        idle(3);
        drive(1, RD, 0, 0, 1, 6'd0,  "R8 read at long limit with auto-close");
        idle(1);
        drive(0, A, 0, 0, 0, 6'd0,   "R2 activate with valid low");
        drive(1, RD, 0, 0, 0, C_CL | C_CCD, "R2 R9 invalid activate left row closed");

        @(negedge clk);
        cmd_valid_i = 1'b0;
        cmd_type_i  = I;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule